// File: doc/BRIEF.md
# Page-mode ROM read controller

This block sits between a synchronous requester and an external asynchronous parallel ROM that can be organised either as 16-bit words or as 8-bit bytes. A requester hands it a starting item address and a beat count on a valid/ready request port. The controller then drives the ROM's chip enable, output enable, width select and address lines. It waits a fixed number of clock cycles for the array to settle, captures the data and returns one result per item on a valid/ready response port. The final beat is flagged.

The ROM answers quickly when only the low in-page address bits move and chip enable stays low. The controller takes advantage of this. Within a burst it holds chip enable and the upper address steady, steps only the in-page field, and uses the short page wait. When a burst crosses a page boundary, it makes a fresh random access with the full wait. In byte mode the ROM's top data pin becomes the lowest address bit, so the controller drives it as an output only in that mode. Between bursts both enables are released, and a float-time turnaround must pass before the next request is taken.

Top module: `rom_page_reader`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, and rom_ce_n and rom_oe_n are both 1.
- R2: The first beat of a burst becomes valid exactly T_FIRST = max(T_RAND, T_OE) cycles after the clock edge that accepts the request.
- R3: A page holds 8 items in word mode (in-page field = item bits 2:0) and 16 items in byte mode (item bits 3:0). A later beat whose item lies in the same page as the previous item becomes valid T_PAGE cycles after the edge that completed the previous response handshake. During that step rom_ce_n stays 0 and the address above the in-page field is unchanged.
- R4: A later beat whose item lies in a different page from the previous item becomes valid T_FIRST cycles after the previous handshake edge.
- R5: With cfg_word = 1 (word mode), rom_word is 1, rom_addr equals the item address, rom_q15_oe is 0, and rsp_data equals all 16 ROM data lines.
- R6: With cfg_word = 0 (byte mode), rom_word is 0, rom_addr equals the item address shifted right by one, rom_q15_out equals item bit 0, and rom_q15_oe is 1. rsp_data carries ROM lines 7:0 with bits 15:8 forced to zero, whatever the ROM drives on lines 15:8.
- R7: A request with req_len = L returns exactly L+1 beats for consecutive items starting at req_addr. rsp_last is 1 on the final beat only.
- R8: While rsp_valid is 1 and rsp_ready is 0, rsp_valid stays 1 and rsp_data and rsp_last hold their values.
- R9: After the final handshake, rom_ce_n and rom_oe_n return to 1 on the next edge. req_ready rises exactly T_TURN cycles after that handshake edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 1 | 1 = 16-bit word organisation, 0 = byte organisation; change only while idle |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to accept |
| req_addr | input | AW+1 | Starting item address (word address in word mode, byte address in byte mode) |
| req_len | input | LENW | Number of beats minus one |
| rsp_valid | output | 1 | Response data available |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | DW | Returned item, zero-extended in byte mode |
| rsp_last | output | 1 | Final beat of the burst |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_word | output | 1 | ROM width select, 1 = word |
| rom_addr | output | AW | ROM word address lines |
| rom_q_in | input | DW | ROM data lines as seen by the controller |
| rom_q15_out | output | 1 | Value for the top data pin when it serves as the byte address bit |
| rom_q15_oe | output | 1 | Enable for driving the top data pin |

## Verification
The assertions assume that cfg_word changes only while req_ready is high. They also assume that the ROM model's data stays valid for as long as its address lines are held. The bench changes the mode only between bursts, after the turnaround has ended. Its ROM model returns a poison value until the required number of cycles has passed since the last address or enable change, with the shorter limit applying only to in-page steps under a steady chip enable. A capture that comes too early therefore shows up as a data mismatch. Request addresses are kept below the top of the word space so that item sequences never wrap.

// File: rtl/rpr_pkg.sv
package rpr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACC,
    ST_RSP,
    ST_TURN
  } rpr_state_e;

  // log2 of items per page in word mode; byte mode adds one bit below
  localparam int unsigned WORD_PAGE_LOG = 3;

  function automatic int unsigned wait_first(int unsigned t_rand, int unsigned t_oe);
    return (t_rand > t_oe) ? t_rand : t_oe;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rpr_timer.sv
module rpr_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == CW'(1));

  // R2: a running wait steps down by one each cycle until reloaded
  a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !load) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/rpr_addr_map.sv
module rpr_addr_map #(
  parameter int unsigned AW = 20
) (
  input  logic [AW:0]   item,
  input  logic          word,
  output logic [AW-1:0] rom_addr,
  output logic          q15_out,
  output logic          q15_oe,
  output logic [AW:0]   next_item,
  output logic          next_same_page
);

  localparam int unsigned WL = rpr_pkg::WORD_PAGE_LOG;

  always_comb begin
    if (word) begin
      rom_addr       = item[AW-1:0];
      q15_out        = 1'b0;
      next_item      = {1'b0, item[AW-1:0] + 1'b1};
      next_same_page = (next_item[AW-1:WL] == item[AW-1:WL]);
    end else begin
      rom_addr       = item[AW:1];
      q15_out        = item[0];
      next_item      = item + 1'b1;
      next_same_page = (next_item[AW:WL+1] == item[AW:WL+1]);
    end
    q15_oe = !word;
  end

endmodule

// File: rtl/rpr_rsp_reg.sv
module rpr_rsp_reg #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          word,
  input  logic [DW-1:0] q,
  input  logic          last_in,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_last,
  output logic          hs
);

  localparam int unsigned BW = DW / 2;

  assign hs = rsp_valid && rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_last  <= 1'b0;
    end else if (capture) begin
      rsp_valid <= 1'b1;
      rsp_data  <= word ? q : {{(DW-BW){1'b0}}, q[BW-1:0]};
      rsp_last  <= last_in;
    end else if (hs) begin
      rsp_valid <= 1'b0;
    end
  end

  // R8: a stalled response keeps its contents
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_last)));

endmodule

// File: rtl/rom_page_reader.sv
module rom_page_reader #(
  parameter int unsigned AW     = 20,
  parameter int unsigned DW     = 16,
  parameter int unsigned LENW   = 5,
  parameter int unsigned T_RAND = 13,
  parameter int unsigned T_PAGE = 4,
  parameter int unsigned T_OE   = 4,
  parameter int unsigned T_TURN = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_word,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW:0]     req_addr,
  input  logic [LENW-1:0] req_len,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [DW-1:0]   rsp_data,
  output logic            rsp_last,
  output logic            rom_ce_n,
  output logic            rom_oe_n,
  output logic            rom_word,
  output logic [AW-1:0]   rom_addr,
  input  logic [DW-1:0]   rom_q_in,
  output logic            rom_q15_out,
  output logic            rom_q15_oe
);

  import rpr_pkg::*;

  localparam int unsigned T_FIRST = wait_first(T_RAND, T_OE);
  localparam int unsigned T_MAX   = max3(T_FIRST, T_PAGE, T_TURN);
  localparam int unsigned CW      = $clog2(T_MAX + 1);
  localparam int unsigned OCW     = $clog2(T_TURN + 1);

  rpr_state_e      st;
  logic [AW:0]     item;
  logic [LENW-1:0] remain;
  logic [AW:0]     next_item;
  logic            same_page;
  logic            expire;
  logic            hs;

  // named internal events
  logic            accept, capture, step, more, pg_step, tmr_load;
  logic [CW-1:0]   tmr_val;

  assign accept   = (st == ST_IDLE) && req_valid;
  assign capture  = (st == ST_ACC) && expire;
  assign step     = (st == ST_RSP) && hs;
  assign more     = (remain != '0);
  assign pg_step  = step && more && same_page;
  assign tmr_load = accept || step;

  always_comb begin
    if (accept)         tmr_val = CW'(T_FIRST);
    else if (!more)     tmr_val = CW'(T_TURN);
    else if (same_page) tmr_val = CW'(T_PAGE);
    else                tmr_val = CW'(T_FIRST);
  end

  assign req_ready = (st == ST_IDLE);
  assign rom_word  = cfg_word;

  rpr_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (expire)
  );

  rpr_addr_map #(.AW(AW)) u_map (
    .item           (item),
    .word           (cfg_word),
    .rom_addr       (rom_addr),
    .q15_out        (rom_q15_out),
    .q15_oe         (rom_q15_oe),
    .next_item      (next_item),
    .next_same_page (same_page)
  );

  rpr_rsp_reg #(.DW(DW)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .word      (cfg_word),
    .q         (rom_q_in),
    .last_in   (!more),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_last  (rsp_last),
    .hs        (hs)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      item     <= '0;
      remain   <= '0;
      rom_ce_n <= 1'b1;
      rom_oe_n <= 1'b1;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          item     <= cfg_word ? {1'b0, req_addr[AW-1:0]} : req_addr;
          remain   <= req_len;
          rom_ce_n <= 1'b0;
          rom_oe_n <= 1'b0;
          st       <= ST_ACC;
        end
        ST_ACC: if (capture) st <= ST_RSP;
        ST_RSP: if (step) begin
          if (more) begin
            item   <= next_item;
            remain <= remain - 1'b1;
            st     <= ST_ACC;
          end else begin
            rom_ce_n <= 1'b1;
            rom_oe_n <= 1'b1;
            st       <= ST_TURN;
          end
        end
        ST_TURN: if (expire) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // cycles spent with chip enable released, saturating at T_TURN
  logic [OCW-1:0] off_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                      off_cnt <= OCW'(T_TURN);
    else if (!rom_ce_n)              off_cnt <= '0;
    else if (off_cnt != OCW'(T_TURN)) off_cnt <= off_cnt + 1'b1;
  end

  // R3: an in-page step keeps chip enable low and the upper address fixed
  a_r3_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pg_step |=> (!rom_ce_n && rom_addr[AW-1:WORD_PAGE_LOG] == $past(rom_addr[AW-1:WORD_PAGE_LOG])));

  // R9: no request is taken before the float turnaround has elapsed
  a_r9_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (off_cnt == OCW'(T_TURN)));

  // R9: idle means both enables released
  a_r9_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (rom_ce_n && rom_oe_n));

  // R6: in byte mode with the chip selected the top data pin is driven
  a_r6_q15_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_ce_n && !rom_word) |-> rom_q15_oe);

  // R7: the last flag accompanies only the final beat
  a_r7_last_final: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_last) |-> (remain == '0));

endmodule

// File: tb/sim_rom_page_reader.sv
module sim_rom_page_reader;

  localparam int unsigned AW = 20, DW = 16, LENW = 5;
  localparam int unsigned T_RAND = 13, T_PAGE = 4, T_OE = 4, T_TURN = 3;
  localparam int unsigned T_FIRST = (T_RAND > T_OE) ? T_RAND : T_OE;

  logic clk = 0, rst_n = 0;
  logic cfg_word = 1, req_valid = 0, rsp_ready = 0;
  logic [AW:0] req_addr = '0;
  logic [LENW-1:0] req_len = '0;
  logic req_ready, rsp_valid, rsp_last;
  logic [DW-1:0] rsp_data, rom_q_in;
  logic rom_ce_n, rom_oe_n, rom_word, rom_q15_out, rom_q15_oe;
  logic [AW-1:0] rom_addr;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  rom_page_reader #(.AW(AW), .DW(DW), .LENW(LENW), .T_RAND(T_RAND),
                    .T_PAGE(T_PAGE), .T_OE(T_OE), .T_TURN(T_TURN)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_last(rsp_last), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
    .rom_word(rom_word), .rom_addr(rom_addr), .rom_q_in(rom_q_in),
    .rom_q15_out(rom_q15_out), .rom_q15_oe(rom_q15_oe));

  function automatic logic [15:0] wdata(logic [AW-1:0] wa);
    return (wa[15:0] * 16'd40503) ^ {12'h0, wa[19:16]} ^ 16'h3C5A;
  endfunction

  function automatic logic [15:0] exp_data(logic [AW:0] it, logic word);
    logic [15:0] w;
    if (word) return wdata(it[AW-1:0]);
    w = wdata(it[AW:1]);
    return {8'h00, it[0] ? w[15:8] : w[7:0]};
  endfunction

  // ROM model: poison until the address has been stable long enough
  logic [AW:0] prev_key = '0;
  logic prev_on = 0;
  int age = 0, need = T_RAND;
  initial rom_q_in = 16'h0BAD;
  always @(posedge clk) begin
    logic [AW:0] key;
    logic on;
    logic [15:0] w;
    #1;
    on  = !rom_ce_n && !rom_oe_n;
    key = {rom_addr, rom_q15_oe ? rom_q15_out : 1'b0};
    if (!on) begin age = 0; need = T_FIRST; end
    else if (!prev_on) begin age = 1; need = T_FIRST; end
    else if (key == prev_key) age = age + 1;
    else if (key[AW:4] == prev_key[AW:4]) begin age = 1; need = T_PAGE; end
    else begin age = 1; need = T_RAND; end
    prev_on = on; prev_key = key;
    w = wdata(rom_addr);
    if (!on || age < need) rom_q_in = 16'h0BAD;
    else if (rom_word) rom_q_in = w;
    else rom_q_in = {8'hEE, (rom_q15_oe && rom_q15_out) ? w[15:8] : w[7:0]};
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #2; endtask

  task automatic burst(logic [AW:0] a, int len, logic word);
    logic [AW:0] it, prev;
    logic [15:0] hold;
    int lat, t, nst, pl, want;
    while (!req_ready) tick();
    cfg_word = word; req_addr = a; req_len = LENW'(len); req_valid = 1;
    tick();
    req_valid = 0;
    pl = word ? 3 : 4;
    prev = '0;
    for (int i = 0; i <= len; i++) begin
      it = word ? {1'b0, a[AW-1:0] + AW'(i)} : a + (AW+1)'(i);
      lat = 0;
      while (!rsp_valid && lat < 100) begin tick(); lat++; end
      if (i == 0) want = T_FIRST;
      else want = ((it >> pl) == (prev >> pl)) ? T_PAGE : T_FIRST;
      if (i == 0) chk(lat == want, "R2", "first latency", lat, want);
      else if (want == T_PAGE) chk(lat == want, "R3", "page latency", lat, want);
      else chk(lat == want, "R4", "cross latency", lat, want);
      if (word)
        chk(rom_word && rom_addr == it[AW-1:0] && !rom_q15_oe, "R5", "word pins",
            {rom_word, rom_q15_oe, rom_addr}, {2'b10, it[AW-1:0]});
      else
        chk(!rom_word && rom_addr == it[AW:1] && rom_q15_oe && rom_q15_out == it[0],
            "R6", "byte pins", {rom_word, rom_q15_oe, rom_q15_out, rom_addr},
            {2'b01, it[0], it[AW:1]});
      hold = rsp_data;
      nst = $urandom % 4;
      for (int s = 0; s < nst; s++) begin
        tick();
        chk(rsp_valid && rsp_data == hold, "R8", "stall hold", rsp_data, hold);
      end
      chk(rsp_data == exp_data(it, word), word ? "R5" : "R6", "data",
          rsp_data, exp_data(it, word));
      chk(rsp_last == (i == len), "R7", "last flag", rsp_last, (i == len));
      rsp_ready = 1;
      tick();
      rsp_ready = 0;
      prev = it;
    end
    chk(rom_ce_n && rom_oe_n && !rsp_valid, "R9", "release after last",
        {rom_ce_n, rom_oe_n, rsp_valid}, 3'b110);
    t = 0;
    while (!req_ready && t < 100) begin
      chk(!rsp_valid, "R7", "no extra beat", rsp_valid, 0);
      tick(); t++;
    end
    chk(t == T_TURN, "R9", "turnaround", t, T_TURN);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) tick();
    chk(req_ready && !rsp_valid && rom_ce_n && rom_oe_n, "R1", "in reset",
        {req_ready, rsp_valid, rom_ce_n, rom_oe_n}, 4'b1011);
    rst_n = 1;
    tick();
    chk(req_ready && !rsp_valid && rom_ce_n && rom_oe_n, "R1", "after reset",
        {req_ready, rsp_valid, rom_ce_n, rom_oe_n}, 4'b1011);
    // directed corners
    burst(21'd6, 4, 1'b1);      // word burst crossing a page
    burst(21'd14, 3, 1'b0);     // byte burst crossing a page
    burst(21'd100, 0, 1'b1);    // single beat word
    burst(21'd7, 0, 1'b0);      // single beat byte, odd byte
    burst(21'd0, 31, 1'b0);     // full length byte, two pages
    burst(21'd15, 1, 1'b0);     // last byte of page then next page
    burst(21'd8, 7, 1'b1);      // exactly one word page
    // constrained random
    for (int k = 0; k < 40; k++)
      burst(21'($urandom % 1000000), $urandom % 32, 1'($urandom % 2));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule